// File: doc/BRIEF.md
# UART Receive Break and Error Statistics

This block sits beside a UART receiver and keeps its error statistics. The receiver gives it one strobe per received character for each error kind: parity, framing and noise. Each kind has its own 16-bit counter. The counters start at a value that software loads and wrap modulo 2^16.

The block also watches the receive line at each bit-rate sample strobe to measure breaks. A break is a low level that lasts at least one whole character, counting the start bit, the data bits, the optional parity bit and the stop bits. Every break counts once in an event counter, however long it lasts. When the line goes high again, the length of the break is stored in character units, rounded down, so the stored value is accurate to within one character.

All five registers can be read and written over a plain register port. A write takes effect one clock later. A read is combinational. The block carries no data stream, so no port has back-pressure: every strobe and every write is accepted in the cycle it is presented.

Top module: `uart_rx_stats`

## Requirements
- R1: After reset, every register reads 0.
- R2: The parity counter (address 0) increments by one for each cycle in which `err_parity` is high, and it wraps from 0xFFFF to 0x0000.
- R3: The framing counter (address 1) increments once per `err_frame` pulse and the noise counter (address 2) increments once per `err_noise` pulse. Each counter is independent of the other error strobes.
- R4: A register write in the same cycle as a hardware increment of that register loads the written value, and the increment is lost.
- R5: A break is recognised only when `rxd` is sampled low on `char_len` consecutive `bit_tick` strobes. A shorter low period changes neither the break counter nor the break length.
- R6: The break counter (address 3) increments exactly once per break, at the tick that completes the first low character, whatever the total length of the break. It wraps from 0xFFFF to 0x0000.
- R7: The break length register (address 4) is loaded with floor(low ticks / `char_len`) at the first high-sampled tick after a break. It holds that value until the next break ends.
- R8: `char_len` gives the total character length in bits, from 2 to 15. Both break recognition and the break length use the value on that pin.
- R9: Register addresses 0 to 4 are readable and writable. Addresses 5 to 7 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| rxd | input | 1 | Receive line, already synchronised |
| char_len | input | 4 | Total character length in bits |
| err_parity | input | 1 | Pulse for each character with a parity error |
| err_frame | input | 1 | Pulse for each character with a framing error |
| err_noise | input | 1 | Pulse for each character with a noise error |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |

## Verification
The assertions check three things on every cycle. An error strobe without a write adds exactly one to its counter, modulo 2^16. A write always wins over a simultaneous strobe. The break counter and the break length move only when a bit tick samples the line at the right level, or when software writes them.

Some behaviour is visible only across many ticks, so only the bench scenarios can show it. These scenarios check that a long break counts once. They check that the stored length is the floor of the low time over the character length, for two different character lengths. They also check that a low period one tick short of a character leaves both break registers untouched.

// File: rtl/uart_stats_pkg.sv
package uart_stats_pkg;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = 4;
  localparam int ADDR_W = 3;
  localparam int N_CNT  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PAR = 3'd0,
    ADDR_FRM = 3'd1,
    ADDR_NOS = 3'd2,
    ADDR_BRK = 3'd3,
    ADDR_LEN = 3'd4
  } stat_addr_e;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] STEP = 1;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (wr)  q <= wdata;      // software write wins
    else if (inc) q <= q + STEP;   // wraps modulo 2^W
  end
endmodule

// File: rtl/break_meter.sv
module break_meter #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rxd,
  input  logic [LEN_W-1:0] char_len,
  output logic             brk_start,
  output logic             brk_end,
  output logic [CNT_W-1:0] brk_chars
);
  localparam logic [LEN_W-1:0] ONE_B  = 1;
  localparam logic [CNT_W-1:0] ONE_C  = 1;
  localparam logic [CNT_W-1:0] MAX_C  = '1;

  logic [LEN_W-1:0] bit_cnt;
  logic [CNT_W-1:0] char_cnt;
  logic             char_done;

  assign char_done = bit_tick && !rxd && ((bit_cnt + ONE_B) == char_len);
  assign brk_start = char_done && (char_cnt == '0);
  assign brk_end   = bit_tick && rxd && (char_cnt != '0);
  assign brk_chars = char_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (bit_tick) begin
      if (rxd) begin
        bit_cnt  <= '0;
        char_cnt <= '0;
      end else if (char_done) begin
        bit_cnt <= '0;
        if (char_cnt != MAX_C) char_cnt <= char_cnt + ONE_C;
      end else begin
        bit_cnt <= bit_cnt + ONE_B;
      end
    end
  end
endmodule

// File: rtl/uart_rx_stats.sv
module uart_rx_stats
  import uart_stats_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LEN_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          rxd,
  input  logic [LW-1:0] char_len,
  input  logic          err_parity,
  input  logic          err_frame,
  input  logic          err_noise,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata
);
  logic              brk_start, brk_end;
  logic [CW-1:0]     brk_chars;
  logic [N_CNT-1:0]  inc_vec;
  logic [CW-1:0]     cnt_q [N_CNT];
  logic [CW-1:0]     brk_len;

  break_meter #(.LEN_W(LW), .CNT_W(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd),
    .char_len(char_len), .brk_start(brk_start), .brk_end(brk_end),
    .brk_chars(brk_chars)
  );

  assign inc_vec = {brk_start, err_noise, err_frame, err_parity};

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    stat_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]),
      .wr(reg_wr && (reg_addr == AW'(i))),
      .wdata(reg_wdata), .q(cnt_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              brk_len <= '0;
    else if (reg_wr && reg_addr == ADDR_LEN) brk_len <= reg_wdata;
    else if (brk_end)                        brk_len <= brk_chars;
  end

  always_comb begin
    case (reg_addr)
      ADDR_PAR: reg_rdata = cnt_q[0];
      ADDR_FRM: reg_rdata = cnt_q[1];
      ADDR_NOS: reg_rdata = cnt_q[2];
      ADDR_BRK: reg_rdata = cnt_q[3];
      ADDR_LEN: reg_rdata = brk_len;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_stats_checker.sv
module uart_rx_stats_checker
  import uart_stats_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             rxd,
  input logic             err_parity,
  input logic             err_frame,
  input logic             reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt_par,
  input logic [CNT_W-1:0] cnt_frm,
  input logic [CNT_W-1:0] cnt_brk,
  input logic [CNT_W-1:0] brk_len
);
  localparam logic [CNT_W-1:0] ONE = 1;

  p_par_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !(reg_wr && reg_addr == ADDR_PAR) |=> cnt_par == $past(cnt_par) + ONE);

  p_frm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !err_frame && !(reg_wr && reg_addr == ADDR_FRM) |=> $stable(cnt_frm));

  p_wr_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_PAR |=> cnt_par == $past(reg_wdata));

  p_brk_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && !rxd) && !(reg_wr && reg_addr == ADDR_BRK) |=> $stable(cnt_brk));

  p_brk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_BRK) |=>
      (cnt_brk == $past(cnt_brk)) || (cnt_brk == $past(cnt_brk) + ONE));

  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && rxd) && !(reg_wr && reg_addr == ADDR_LEN) |=> $stable(brk_len));
endmodule

bind uart_rx_stats uart_rx_stats_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd),
  .err_parity(err_parity), .err_frame(err_frame),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cnt_par(cnt_q[0]), .cnt_frm(cnt_q[1]), .cnt_brk(cnt_q[3]),
  .brk_len(brk_len)
);

// File: tb/uart_rx_stats_bench.sv
`timescale 1ns/1ps
module uart_rx_stats_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bit_tick = 0;
  logic        rxd = 1;
  logic [3:0]  char_len = 4'd10;
  logic        err_parity = 0, err_frame = 0, err_noise = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_stats u_uart_rx_stats (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd),
    .char_len(char_len), .err_parity(err_parity), .err_frame(err_frame),
    .err_noise(err_noise), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check_reg(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse_err(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      err_parity = (which == 0); err_frame = (which == 1); err_noise = (which == 2);
      @(negedge clk);
      err_parity = 0; err_frame = 0; err_noise = 0;
    end
  endtask

  task automatic line_bits(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = lvl; bit_tick = 1;
      @(negedge clk);
      bit_tick = 0;
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) check_reg(3'(a), 16'h0, "R1");
    check_reg(3'd7, 16'h0, "R9");
  endtask

  task automatic t_parity;
    pulse_err(0, 3);
    check_reg(3'd0, 16'd3, "R2");
    wr_reg(3'd0, 16'hFFFF);
    pulse_err(0, 1);
    check_reg(3'd0, 16'h0000, "R2");
  endtask

  task automatic t_frame_noise;
    pulse_err(1, 2);
    pulse_err(2, 1);
    check_reg(3'd1, 16'd2, "R3");
    check_reg(3'd2, 16'd1, "R3");
    check_reg(3'd0, 16'd0, "R3");
  endtask

  task automatic t_priority;
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd1; reg_wdata = 16'h1234; err_frame = 1;
    @(negedge clk);
    reg_wr = 0; err_frame = 0;
    check_reg(3'd1, 16'h1234, "R4");
  endtask

  task automatic t_unmapped;
    wr_reg(3'd6, 16'hBEEF);
    check_reg(3'd6, 16'h0, "R9");
    check_reg(3'd0, 16'h0, "R9");
  endtask

  task automatic t_short_low;
    line_bits(1, 2); line_bits(0, 9); line_bits(1, 2);
    check_reg(3'd3, 16'd0, "R5");
    check_reg(3'd4, 16'd0, "R5");
  endtask

  task automatic t_breaks;
    line_bits(0, 10);
    check_reg(3'd3, 16'd1, "R6");
    line_bits(0, 10); line_bits(1, 1);
    check_reg(3'd3, 16'd1, "R6");
    check_reg(3'd4, 16'd2, "R7");
    line_bits(0, 25); line_bits(1, 1);
    check_reg(3'd3, 16'd2, "R6");
    check_reg(3'd4, 16'd2, "R7");
    line_bits(0, 300);
    check_reg(3'd4, 16'd2, "R7");
    line_bits(1, 1);
    check_reg(3'd3, 16'd3, "R6");
    check_reg(3'd4, 16'd30, "R7");
    line_bits(0, 5); line_bits(1, 1);
    check_reg(3'd4, 16'd30, "R7");
  endtask

  task automatic t_len7;
    char_len = 4'd7;
    line_bits(0, 15); line_bits(1, 1);
    check_reg(3'd3, 16'd4, "R8");
    check_reg(3'd4, 16'd2, "R8");
    wr_reg(3'd3, 16'hFFFF);
    line_bits(0, 7); line_bits(1, 1);
    check_reg(3'd3, 16'h0000, "R6");
    check_reg(3'd4, 16'd1, "R8");
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_parity();
    t_frame_noise();
    t_priority();
    t_unmapped();
    t_short_low();
    t_breaks();
    t_len7();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule